// File: doc/BRIEF.md
# Character-to-Word Packer

The block builds a word of eleven 4-bit digits from characters that arrive one at a time with a valid strobe. Each accepted character enters at the most-significant digit, and the whole word moves one digit toward the least-significant end. The first character therefore ends up in digit 0, and a consumer that works least-significant digit first receives the data in the order it needs.

A word closes in one of two ways. Either the number of stored characters reaches a programmed limit, or a character equal to a programmed fill code arrives. The fill code is never stored. If fewer than eleven characters were stored, the block keeps shifting zeros in from the top, one digit per clock, until the first character sits in digit 0. It then raises a one-cycle ready flag and drains the 44-bit word serially, least-significant bit first, one bit per clock. While a word is being aligned or drained, the block shows busy and ignores new characters. When the drain ends, the register and the character count are empty and the block accepts the next word.

Top module: `digit_word_packer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o, word_ready_o, out_valid_o and ser_o are all 0.
- R2: In drain cycle j (j = 0..43), ser_o equals bit (j mod 4) of digit j/4, where digit 0 holds the first accepted character of the word. ser_o is 0 whenever out_valid_o is 0.
- R3: A word closes when the count of stored characters reaches max_chars_i. A max_chars_i of 0 or above 11 acts as 11.
- R4: A character equal to fill_code_i closes the word and is not stored. Every digit from the stored count up to digit 10 drains as zero. The fill check takes priority over storing.
- R5: Let the closing character be sampled at clock edge E, with k characters stored. word_ready_o is then high for exactly one cycle, beginning 11-k edges after E. out_valid_o is high for the 44 cycles that follow.
- R6: busy_o is high from the closing edge until the end of the last drain cycle. A character presented while busy_o is high has no effect on any word.
- R7: After a drain, the character count and the register are empty. A following shorter word drains zeros in every digit it did not fill.
- R8: A fill character received with no characters stored gives 11 alignment cycles and then 44 zero bits.
- R9: Characters presented on consecutive clocks are each accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_i | input | 4 | Incoming character |
| char_valid_i | input | 1 | char_i is valid in this cycle |
| fill_code_i | input | 4 | Code that ends a word early |
| max_chars_i | input | 4 | Characters per word (0 or >11 means 11) |
| ser_o | output | 1 | Serial word data, LSB first |
| out_valid_o | output | 1 | ser_o carries a word bit |
| word_ready_o | output | 1 | One-cycle flag: aligned word complete |
| busy_o | output | 1 | Characters are being rejected |

## Verification
All results are timed from the edge that samples the closing character. word_ready_o is due 11-k edges later, in the first cycle of a 44-cycle out_valid_o window. Inputs are driven on the falling edge, and the outputs are compared on every falling edge with a behavioural model that advances at each rising edge. Each result is therefore checked in the cycle it is due, neither early nor late. Whole-word checks gather the serial bits across the window and compare both the assembled value and the window length.

// File: rtl/digit_pack_pkg.sv
package digit_pack_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INSERT,
    OP_ALIGN,
    OP_DRAIN,
    OP_CLEAR
  } sh_op_e;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_ALIGN,
    ST_READY,
    ST_DRAIN
  } seq_st_e;
endpackage

// File: rtl/char_limit.sv
module char_limit #(
  parameter int NUM_DIGITS = 11,
  localparam int CNT_W = $clog2(NUM_DIGITS + 1)
) (
  input  logic [CNT_W-1:0] max_chars_i,
  output logic [CNT_W-1:0] lim_o
);
  localparam logic [CNT_W-1:0] FullC = CNT_W'(NUM_DIGITS);

  // out-of-range limit means a full word
  always_comb begin
    if (max_chars_i == '0 || max_chars_i > FullC) lim_o = FullC;
    else lim_o = max_chars_i;
  end
endmodule

// File: rtl/digit_shreg.sv
module digit_shreg
  import digit_pack_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  sh_op_e             op_i,
  input  logic [DIGIT_W-1:0] char_i,
  output logic               lsb_o
);
  localparam int WORD_W = DIGIT_W * NUM_DIGITS;

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    logic [DIGIT_W-1:0] up_dig;
    logic               up_bit;
    logic [DIGIT_W-1:0] dig_d;

    if (i == NUM_DIGITS - 1) begin : g_top
      assign up_dig = (op_i == OP_INSERT) ? char_i : '0;
      assign up_bit = 1'b0;
    end else begin : g_mid
      assign up_dig = word_q[(i+1)*DIGIT_W +: DIGIT_W];
      assign up_bit = word_q[(i+1)*DIGIT_W];
    end

    always_comb begin
      unique case (op_i)
        OP_INSERT, OP_ALIGN: dig_d = up_dig;
        OP_DRAIN:            dig_d = {up_bit, word_q[i*DIGIT_W+1 +: DIGIT_W-1]};
        OP_CLEAR:            dig_d = '0;
        default:             dig_d = word_q[i*DIGIT_W +: DIGIT_W];
      endcase
    end

    assign word_d[i*DIGIT_W +: DIGIT_W] = dig_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign lsb_o = word_q[0];
endmodule

// File: rtl/word_seq.sv
module word_seq
  import digit_pack_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 11,
  localparam int CNT_W = $clog2(NUM_DIGITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIGIT_W-1:0] char_i,
  input  logic               char_valid_i,
  input  logic [DIGIT_W-1:0] fill_code_i,
  input  logic [CNT_W-1:0]   lim_i,
  output sh_op_e             op_o,
  output logic               out_valid_o,
  output logic               word_ready_o,
  output logic               busy_o
);
  localparam int WORD_W = DIGIT_W * NUM_DIGITS;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] FullC   = CNT_W'(NUM_DIGITS);
  localparam logic [BIT_W-1:0] LastBit = BIT_W'(WORD_W - 1);

  seq_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0]  gap_q, gap_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              accept, is_fill;

  assign accept  = char_valid_i && (st_q == ST_COLLECT);
  assign is_fill = (char_i == fill_code_i);
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    gap_d = gap_q;
    bit_d = bit_q;
    op_o  = OP_HOLD;
    unique case (st_q)
      ST_COLLECT: begin
        if (accept) begin
          if (is_fill) begin
            // fill is dropped; remaining digits are zero-shifted
            gap_d = FullC - cnt_q;
            st_d  = ST_ALIGN;
          end else begin
            op_o  = OP_INSERT;
            cnt_d = cnt_inc;
            if (cnt_inc >= lim_i) begin
              gap_d = FullC - cnt_inc;
              st_d  = (cnt_inc == FullC) ? ST_READY : ST_ALIGN;
            end
          end
        end
      end
      ST_ALIGN: begin
        op_o  = OP_ALIGN;
        gap_d = gap_q - 1'b1;
        if (gap_q == CNT_W'(1)) st_d = ST_READY;
      end
      ST_READY: begin
        st_d  = ST_DRAIN;
        bit_d = '0;
      end
      ST_DRAIN: begin
        op_o  = OP_DRAIN;
        bit_d = bit_q + 1'b1;
        if (bit_q == LastBit) begin
          op_o  = OP_CLEAR;
          cnt_d = '0;
          bit_d = '0;
          st_d  = ST_COLLECT;
        end
      end
      default: st_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_COLLECT;
      cnt_q <= '0;
      gap_q <= '0;
      bit_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      gap_q <= gap_d;
      bit_q <= bit_d;
    end
  end

  assign out_valid_o  = (st_q == ST_DRAIN);
  assign word_ready_o = (st_q == ST_READY);
  assign busy_o       = (st_q != ST_COLLECT);
endmodule

// File: rtl/digit_word_packer.sv
module digit_word_packer
  import digit_pack_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 11,
  localparam int CNT_W = $clog2(NUM_DIGITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIGIT_W-1:0] char_i,
  input  logic               char_valid_i,
  input  logic [DIGIT_W-1:0] fill_code_i,
  input  logic [CNT_W-1:0]   max_chars_i,
  output logic               ser_o,
  output logic               out_valid_o,
  output logic               word_ready_o,
  output logic               busy_o
);
  sh_op_e           op;
  logic [CNT_W-1:0] lim;
  logic             lsb;

  char_limit #(.NUM_DIGITS(NUM_DIGITS)) u_limit (
    .max_chars_i(max_chars_i),
    .lim_o      (lim)
  );

  word_seq #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .char_i      (char_i),
    .char_valid_i(char_valid_i),
    .fill_code_i (fill_code_i),
    .lim_i       (lim),
    .op_o        (op),
    .out_valid_o (out_valid_o),
    .word_ready_o(word_ready_o),
    .busy_o      (busy_o)
  );

  digit_shreg #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_shreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .char_i(char_i),
    .lsb_o (lsb)
  );

  assign ser_o = out_valid_o & lsb;
endmodule

// File: rtl/digit_word_packer_chk.sv
module digit_word_packer_chk #(
  parameter int WORD_W = 44
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ser_o,
  input logic out_valid_o,
  input logic word_ready_o,
  input logic busy_o
);
  localparam int RUN_W = $clog2(WORD_W + 1);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (out_valid_o) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  // R5
  ready_then_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |=> (out_valid_o && !word_ready_o));
  // R5
  drain_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(word_ready_o));
  // R5
  drain_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> (run_q == RUN_W'(WORD_W)));
  // R5
  drain_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (run_q < RUN_W'(WORD_W)));
  // R6
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o || word_ready_o) |-> busy_o);
  // R2
  ser_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !ser_o);
  // R7
  idle_after_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> !busy_o);
endmodule

bind digit_word_packer digit_word_packer_chk #(.WORD_W(DIGIT_W * NUM_DIGITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_o       (ser_o),
  .out_valid_o (out_valid_o),
  .word_ready_o(word_ready_o),
  .busy_o      (busy_o)
);

// File: tb/digit_word_packer_bench.sv
`timescale 1ns/1ps
module digit_word_packer_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] char_i = '0;
  logic       char_valid_i = 1'b0;
  logic [3:0] fill_code_i = 4'hF;
  logic [3:0] max_chars_i = 4'd11;
  logic       ser_o, out_valid_o, word_ready_o, busy_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  digit_word_packer u_digit_word_packer (
    .clk_i(clk), .rst_ni(rst_ni), .char_i(char_i), .char_valid_i(char_valid_i),
    .fill_code_i(fill_code_i), .max_chars_i(max_chars_i), .ser_o(ser_o),
    .out_valid_o(out_valid_o), .word_ready_o(word_ready_o), .busy_o(busy_o)
  );

  // behavioural reference: 0 collect, 1 align, 2 ready, 3 drain
  int mdl_phase = 0;
  int mdl_wait  = 0;
  int mdl_bit   = 0;
  int mdl_q[$];

  function automatic int lim_of(input int m);
    return (m == 0 || m > 11) ? 11 : m;
  endfunction

  function automatic logic mdl_ser();
    int d = mdl_bit / 4;
    if (mdl_phase != 3 || d >= mdl_q.size()) return 1'b0;
    return logic'((mdl_q[d] >> (mdl_bit % 4)) & 1);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mdl_phase <= 0; mdl_wait <= 0; mdl_bit <= 0; mdl_q.delete();
    end else begin
      case (mdl_phase)
        0: if (char_valid_i) begin
             if (char_i == fill_code_i) begin
               mdl_wait = 11 - mdl_q.size();
               mdl_phase = 1;
             end else begin
               mdl_q.push_back(int'(char_i));
               if (mdl_q.size() >= lim_of(int'(max_chars_i))) begin
                 mdl_wait = 11 - mdl_q.size();
                 mdl_phase = (mdl_wait == 0) ? 2 : 1;
               end
             end
           end
        1: begin mdl_wait = mdl_wait - 1; if (mdl_wait == 0) mdl_phase = 2; end
        2: begin mdl_phase = 3; mdl_bit = 0; end
        default: begin
          mdl_bit = mdl_bit + 1;
          if (mdl_bit == 44) begin mdl_phase = 0; mdl_q.delete(); end
        end
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R2", "ser_o", int'(ser_o), int'(mdl_ser()));
      chk("R5", "word_ready_o", int'(word_ready_o), int'(mdl_phase == 2));
      chk("R5", "out_valid_o", int'(out_valid_o), int'(mdl_phase == 3));
      chk("R6", "busy_o", int'(busy_o), int'(mdl_phase != 0));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_char(input logic [3:0] c);
    char_valid_i = 1'b1;
    char_i = c;
    @(negedge clk);
    char_valid_i = 1'b0;
  endtask

  int exp_chars[$];

  task automatic expect_word(input string req);
    logic [43:0] exp_w = '0;
    logic [43:0] got_w = '0;
    int n = 0;
    foreach (exp_chars[i]) exp_w[i*4 +: 4] = exp_chars[i][3:0];
    while (!out_valid_o) @(negedge clk);
    while (out_valid_o) begin
      if (n < 44) got_w[n] = ser_o;
      n++;
      @(negedge clk);
    end
    checks++;
    if (got_w != exp_w) begin
      errors++;
      $display("FAIL %s word actual=%h expected=%h", req, got_w, exp_w);
    end
    chk(req, "drain length", n, 44);
    chk("R7", "idle after drain", int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy in reset", int'(busy_o), 0);
    chk("R1", "ready in reset", int'(word_ready_o), 0);
    chk("R1", "valid in reset", int'(out_valid_o), 0);
    chk("R1", "ser in reset", int'(ser_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy_o), 0);

    // R9 / R2: full word, back to back
    exp_chars = {1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 14};
    foreach (exp_chars[i]) send_char(exp_chars[i][3:0]);
    expect_word("R9");

    // R3: limit 4, gaps between characters; word_ready 7 edges after close
    max_chars_i = 4'd4;
    exp_chars = {3, 7, 9, 2};
    for (int i = 0; i < 4; i++) begin
      send_char(exp_chars[i][3:0]);
      if (i < 3) repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R5", "ready not yet", int'(word_ready_o), 0);
    @(negedge clk);
    chk("R5", "ready after 7 align", int'(word_ready_o), 1);
    expect_word("R3");

    // R4: fill ends early
    max_chars_i = 4'd11;
    exp_chars = {5, 10};
    send_char(4'h5); send_char(4'hA); send_char(4'hF);
    expect_word("R4");

    // R8: fill first
    exp_chars = {};
    send_char(4'hF);
    repeat (10) @(negedge clk);
    chk("R8", "align still running", int'(word_ready_o), 0);
    @(negedge clk);
    chk("R8", "ready after 11 align", int'(word_ready_o), 1);
    expect_word("R8");

    // R3: limit 0 acts as 11; fill code changed so old fill value is data
    max_chars_i = 4'd0;
    fill_code_i = 4'h0;
    exp_chars = {15, 14, 13, 12, 11, 10, 9, 8, 7, 6, 5};
    foreach (exp_chars[i]) send_char(exp_chars[i][3:0]);
    expect_word("R3");

    // R6: characters while busy are ignored; R7 next word short
    max_chars_i = 4'd15;
    fill_code_i = 4'hF;
    exp_chars = {9, 9, 9, 9, 9, 9, 9, 9, 9, 9, 9};
    fork
      begin
        foreach (exp_chars[i]) send_char(4'h9);
        char_valid_i = 1'b1; char_i = 4'h6;
        while (busy_o) @(negedge clk);
        char_valid_i = 1'b0;
      end
      expect_word("R6");
    join
    max_chars_i = 4'd2;
    exp_chars = {1, 3};
    send_char(4'h1); send_char(4'h3);
    expect_word("R7");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule